// File: doc/BRIEF.md
# Occupancy-Counted Synchronous FIFO with Full Pass-Through Writes

This block is a single-clock first-in first-out buffer. Its storage is a register array whose entry width and entry count are parameters. The entry count does not have to be a power of two. A producer offers words on the write side. A consumer sees the oldest stored word at all times on the read side. When the consumer raises its read enable, it takes that word, and the following word appears after the next rising clock edge.

The empty and full indications come from a separate occupancy counter. They are not derived from comparing the two pointers. A write offered while the buffer is full is still taken if the consumer reads in the same cycle, because that read frees a slot at the same edge. This pass-through can continue on every cycle.

The `wr_ok` output is high during any cycle in which the offered write is taken. A producer can therefore see whether a write made while full succeeded. Reset is synchronous and active-high. It clears the pointers and the counter but leaves the stored words untouched.

Top module: `occupancy_fifo`

## Requirements
- R1: While `rst` is high at a rising edge, the occupancy is cleared. In the cycle after reset, `empty` is 1 and `full` is 0.
- R2: Words leave in the order they were taken. `rd_data` always shows the oldest stored word. A taken read makes the next word visible in the cycle after the edge.
- R3: `empty` is 1 exactly when no words are stored. `full` is 1 exactly when DEPTH words are stored. The two are never 1 together.
- R4: A write offered while `full` is 1 and `rd_en` is 0 is dropped. `wr_ok` stays 0, `full` stays 1, and the stored words come out unchanged when the buffer is later drained.
- R5: A read offered while `empty` is 1 is ignored. `empty` stays 1, and later writes come out in order with none skipped.
- R6: While `full` is 1, a cycle with both `wr_en` and `rd_en` at 1 takes both operations. `full` stays 1 and ordering is kept, for any number of consecutive such cycles.
- R7: While `empty` is 1, a cycle with both enables at 1 takes only the write. `empty` is 0 in the next cycle, and the written word is the one shown.
- R8: `wr_ok` is 1 in a cycle exactly when `wr_en` is 1 and either `full` is 0 or `rd_en` is 1.
- R9: Both pointers wrap from location DEPTH-1 back to 0, including for a DEPTH that is not a power of two (the default is 6). Ordering holds across many wraps.
- R10: When the buffer is neither empty nor full and both a read and a write are taken, the occupancy is unchanged. A taken write alone raises it by one, and a taken read alone lowers it by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of pointers and counter |
| wr_data | input | WIDTH | Word offered by the producer |
| wr_en | input | 1 | Producer requests a write |
| full | output | 1 | DEPTH words are stored |
| wr_ok | output | 1 | The write offered this cycle is taken at the coming edge |
| rd_data | output | WIDTH | Oldest stored word |
| rd_en | input | 1 | Consumer takes the word on `rd_data` |
| empty | output | 1 | No words are stored |

## Verification
The scoreboard is exercised with several input patterns:
- Reads on an empty buffer, which separate an ignored read from a spurious pointer advance.
- Both enables on an empty buffer, which separate write-only acceptance from a phantom read.
- Writes on a full buffer with and without a read. These separate the dropped write from the pass-through write, and catch a design that rejects both or accepts both.
- A long run of paired reads and writes at mid occupancy, followed by a mixed pattern. Together with the six-entry default, these drive the pointers through many non-power-of-two wraps, where a power-of-two wrap or a wrong count update shows up as reordered or lost words.

// File: rtl/ofifo_pkg.sv
package ofifo_pkg;
   // index width for a given number of locations, never below one bit
   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // width needed to hold every value from 0 to n inclusive
   function automatic int cnt_bits(input int n);
      return $clog2(n + 1);
   endfunction

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/ofifo_ptr.sv
module ofifo_ptr #(
   parameter int DEPTH = 6,
   parameter int PW    = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   output logic [PW-1:0] ptr
);
   import ofifo_pkg::*;

   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   logic [PW-1:0] nxt;

   generate
      if (is_pow2(DEPTH) && (DEPTH > 1)) begin : g_natural
         // a power-of-two depth wraps by plain overflow
         always_comb nxt = ptr + PW'(1);
      end else begin : g_compare
         always_comb nxt = (ptr == LAST) ? '0 : ptr + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         ptr <= '0;
      else if (adv)
         ptr <= nxt;
   end
endmodule

// File: rtl/ofifo_occ.sv
module ofifo_occ #(
   parameter int DEPTH = 6,
   parameter int CW    = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          inc,
   input  logic          dec,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   localparam logic [CW-1:0] TOP = CW'(DEPTH);

   always_ff @(posedge clk) begin
      if (rst)
         count <= '0;
      else begin
         case ({inc, dec})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   always_comb begin
      full  = (count == TOP);
      empty = (count == '0);
   end
endmodule

// File: rtl/ofifo_store.sv
module ofifo_store #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 6,
   parameter int PW    = 3
) (
   input  logic             clk,
   input  logic             we,
   input  logic [PW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [PW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] cells [DEPTH];

   // storage holds no reset: every cell is written before it can be read
   always_ff @(posedge clk) begin
      if (we)
         cells[waddr] <= wdata;
   end

   always_comb rdata = cells[raddr];
endmodule

// File: rtl/occupancy_fifo.sv
module occupancy_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             wr_en,
   output logic             full,
   output logic             wr_ok,
   output logic [WIDTH-1:0] rd_data,
   input  logic             rd_en,
   output logic             empty
);
   import ofifo_pkg::*;

   localparam int PW = idx_bits(DEPTH);
   localparam int CW = cnt_bits(DEPTH);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("occupancy_fifo: WIDTH must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("occupancy_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic          take_wr;
   logic          take_rd;
   logic [PW-1:0] wp;
   logic [PW-1:0] rp;
   logic [CW-1:0] occ_count;

   // a full buffer still takes a write when a read frees a slot at the same edge
   always_comb begin
      take_rd = rd_en & ~empty;
      take_wr = wr_en & (~full | rd_en);
      wr_ok   = take_wr;
   end

   ofifo_ptr #(.DEPTH(DEPTH), .PW(PW)) u_wptr (
      .clk (clk),
      .rst (rst),
      .adv (take_wr),
      .ptr (wp)
   );

   ofifo_ptr #(.DEPTH(DEPTH), .PW(PW)) u_rptr (
      .clk (clk),
      .rst (rst),
      .adv (take_rd),
      .ptr (rp)
   );

   ofifo_occ #(.DEPTH(DEPTH), .CW(CW)) u_occ (
      .clk   (clk),
      .rst   (rst),
      .inc   (take_wr),
      .dec   (take_rd),
      .count (occ_count),
      .full  (full),
      .empty (empty)
   );

   ofifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PW(PW)) u_mem (
      .clk   (clk),
      .we    (take_wr),
      .waddr (wp),
      .wdata (wr_data),
      .raddr (rp),
      .rdata (rd_data)
   );
endmodule

// File: rtl/ofifo_chk.sv
module ofifo_chk #(
   parameter int DEPTH = 6,
   parameter int CW    = 3
) (
   input logic          clk,
   input logic          rst,
   input logic          wr_en,
   input logic          rd_en,
   input logic          full,
   input logic          empty,
   input logic          wr_ok,
   input logic [CW-1:0] count
);
   p_reset_clear_r1: assert property (@(posedge clk) rst |=> (empty && !full));

   p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
      !(full && empty));

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
      (full && wr_en && !rd_en) |=> full);

   p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
      (empty && rd_en && !wr_en) |=> empty);

   p_full_pass_r6: assert property (@(posedge clk) disable iff (rst)
      (full && wr_en && rd_en) |=> full);

   p_empty_both_r7: assert property (@(posedge clk) disable iff (rst)
      (empty && wr_en) |=> !empty);

   p_blocked_write_r8: assert property (@(posedge clk) disable iff (rst)
      (full && !rd_en) |-> !wr_ok);

   p_pair_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (!full && !empty && wr_en && rd_en) |=> $stable(count));

   p_count_range_r3: assert property (@(posedge clk) disable iff (rst)
      count <= CW'(DEPTH));
endmodule

bind occupancy_fifo ofifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk   (clk),
   .rst   (rst),
   .wr_en (wr_en),
   .rd_en (rd_en),
   .full  (full),
   .empty (empty),
   .wr_ok (wr_ok),
   .count (occ_count)
);

// File: tb/occupancy_fifo_tb.sv
`timescale 1ns/1ps
module occupancy_fifo_tb;
   localparam int W = 8;
   localparam int D = 6;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] wr_data = '0;
   logic         wr_en = 1'b0;
   logic         rd_en = 1'b0;
   logic         full, wr_ok, empty;
   logic [W-1:0] rd_data;

   int n_vec  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [W-1:0] sb [$];
   int           m_cnt = 0;
   bit           chk_on = 1'b0;
   bit           exp_full, exp_empty, exp_wrok, exp_rd;
   string        tag = "R1";

   always #4 clk = ~clk;

   occupancy_fifo #(.WIDTH(W), .DEPTH(D)) u_dut (
      .clk(clk), .rst(rst), .wr_data(wr_data), .wr_en(wr_en), .full(full),
      .wr_ok(wr_ok), .rd_data(rd_data), .rd_en(rd_en), .empty(empty)
   );

   // driver: applies one cycle of stimulus and predicts its outcome
   task automatic step(input bit w, input bit r, input logic [W-1:0] d);
      bit wacc, racc;
      @(posedge clk);
      #1;
      wr_en   = w;
      rd_en   = r;
      wr_data = d;
      exp_full  = (m_cnt == D);
      exp_empty = (m_cnt == 0);
      wacc = w && ((m_cnt < D) || r);
      racc = r && (m_cnt > 0);
      exp_wrok = wacc;
      exp_rd   = racc;
      if (wacc) sb.push_back(d);
      m_cnt = m_cnt + (wacc ? 1 : 0) - (racc ? 1 : 0);
      chk_on = 1'b1;
   endtask

   // monitor: compares flags and popped words at the falling edge
   always @(negedge clk) begin
      if (chk_on && !finished) begin
         n_vec++;
         if (full !== exp_full) begin
            n_fail++;
            $display("FAIL %s/R3 full actual=%b expected=%b", tag, full, exp_full);
         end
         n_vec++;
         if (empty !== exp_empty) begin
            n_fail++;
            $display("FAIL %s/R3 empty actual=%b expected=%b", tag, empty, exp_empty);
         end
         n_vec++;
         if (wr_ok !== exp_wrok) begin
            n_fail++;
            $display("FAIL %s/R8 wr_ok actual=%b expected=%b", tag, wr_ok, exp_wrok);
         end
         if (exp_rd) begin
            n_vec++;
            if (sb.size() == 0) begin
               n_fail++;
               $display("FAIL %s/R2 read with empty scoreboard actual=%h expected=none", tag, rd_data);
            end else begin
               if (rd_data !== sb[0]) begin
                  n_fail++;
                  $display("FAIL %s/R2 rd_data actual=%h expected=%h", tag, rd_data, sb[0]);
               end
               void'(sb.pop_front());
            end
         end
      end
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         finished = 1'b1;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      rst = 1'b0;
      exp_full = 1'b0; exp_empty = 1'b1; exp_wrok = 1'b0; exp_rd = 1'b0;
      chk_on = 1'b1;

      // R5: reads on an empty buffer are ignored
      @(posedge clk); tag = "R5";
      step(0, 1, 8'h00);
      step(0, 1, 8'h00);
      step(1, 0, 8'h11);
      step(0, 1, 8'h00);
      step(0, 0, 8'h00);

      // R7: both enables on empty take only the write
      tag = "R7";
      step(1, 1, 8'h22);
      step(0, 0, 8'h00);
      step(0, 1, 8'h00);
      step(0, 0, 8'h00);

      // R4: fill, then writes without a read are dropped
      tag = "R4";
      for (int i = 0; i < D; i++) step(1, 0, 8'h30 + 8'(i));
      for (int i = 0; i < 3; i++) step(1, 0, 8'hE0 + 8'(i));

      // R6: pass-through writes while full
      tag = "R6";
      for (int i = 0; i < 5; i++) step(1, 1, 8'h50 + 8'(i));
      step(0, 0, 8'h00);
      for (int i = 0; i < D + 1; i++) step(0, 1, 8'h00);

      // R10 and R9: paired traffic at mid occupancy over many wraps
      tag = "R10";
      for (int i = 0; i < 3; i++) step(1, 0, 8'h70 + 8'(i));
      for (int i = 0; i < 20; i++) step(1, 1, 8'h80 + 8'(i));
      tag = "R9";
      for (int i = 0; i < 60; i++) step((i % 3) != 0, (i % 2) == 1, 8'hA0 + 8'(i));
      for (int i = 0; i < D + 2; i++) step(0, 1, 8'h00);

      @(posedge clk); #1;
      chk_on = 1'b0;
      n_vec++;
      if (sb.size() != 0) begin
         n_fail++;
         $display("FAIL R2 words left in scoreboard actual=%0d expected=0", sb.size());
      end
      @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end
endmodule